// File: doc/BRIEF.md
# Supply Switchover Time Stamp Recorder

This block keeps two records of the calendar time taken at supply switchover events. Two strobes mark the events: one for each move from the main supply onto the backup battery, and one for each return from the battery to the main supply. On each strobe the block copies the current BCD time (seconds, minutes, hours, date and month) into the record for that direction. A host reads both records from two output words. A clear strobe empties both records.

The two records follow opposite retention policies. The battery-entry record keeps the first event after a clear and holds it against later events, so the start of a power outage survives a run of brief dropouts. The main-return record is overwritten on every return, so it always shows the most recent one. An empty record is all zeros, date and month included. A real calendar date is never zero, so an all-zero record means that no event has been recorded since reset or the last clear.

Top module: `pwr_xfer_stamp`

## Requirements
- R1: After reset both `bat_stamp` and `main_stamp` are all zeros.
- R2: When `to_bat_stb` is high and the battery-entry record is empty, `bat_stamp` takes the time inputs present in that cycle. The new value is visible after the next rising clock edge.
- R3: Once the battery-entry record holds an event, later `to_bat_stb` pulses leave `bat_stamp` unchanged until a clear.
- R4: Each `to_main_stb` pulse loads the time inputs of that cycle into `main_stamp`, replacing any earlier value. The new value is visible after the next rising clock edge.
- R5: A `stamp_clr` pulse sets every byte of both records to 00h after the next edge, date and month included. It also re-arms the battery-entry record for a fresh first event.
- R6: When `stamp_clr` arrives in the same cycle as either strobe, the clear takes effect and the strobe is discarded.
- R7: Both stamp words use the same layout. Seconds sit in bits [7:0], minutes in [15:8], hours in [23:16], date in [31:24] and month in [39:32]. Each field is copied unchanged from its input.
- R8: A strobe for one direction never changes the other record. With no strobe and no clear, both records hold their values while the time inputs move.
- R9: A battery-entry capture taken with a non-zero date produces a non-zero `bat_stamp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tm_sec | input | 8 | Current seconds, BCD |
| tm_min | input | 8 | Current minutes, BCD |
| tm_hour | input | 8 | Current hours, BCD |
| tm_date | input | 8 | Current day of month, BCD |
| tm_month | input | 8 | Current month, BCD |
| to_bat_stb | input | 1 | One-cycle pulse: supply moved from main onto battery |
| to_main_stb | input | 1 | One-cycle pulse: supply moved from battery back to main |
| stamp_clr | input | 1 | One-cycle pulse: empty both records |
| bat_stamp | output | 40 | Battery-entry record (first event kept) |
| main_stamp | output | 40 | Main-return record (last event kept) |

## Verification
The properties assume that strobes and the clear are single-cycle pulses sampled on the clock. They also assume that the date input is non-zero whenever it carries a valid time, since the non-empty check depends on it. The stimulus changes every input at the falling edge. It gives each event its own time values, so that a stale capture differs from a fresh one. It uses a date of zero only where an empty result is expected anyway. Coinciding clear and strobe pulses are applied on purpose, in both directions, to exercise the priority rule.

// File: rtl/pwr_stamp_pkg.sv
package pwr_stamp_pkg;

    localparam int FIELD_W  = 8;
    localparam int N_FIELDS = 5;
    localparam int STAMP_W  = FIELD_W * N_FIELDS;

    // Index of each record inside the slot array
    localparam int SLOT_BAT  = 0;
    localparam int SLOT_MAIN = 1;
    localparam int N_SLOTS   = 2;

    typedef logic [FIELD_W-1:0] bcd_t;

    // Month sits in the top byte, seconds in the bottom byte
    typedef struct packed {
        bcd_t month;
        bcd_t date;
        bcd_t hour;
        bcd_t minute;
        bcd_t second;
    } stamp_t;

    typedef enum logic {
        KEEP_FIRST = 1'b0,
        KEEP_LAST  = 1'b1
    } keep_policy_e;

    localparam stamp_t STAMP_EMPTY = '0;

    function automatic stamp_t pack_time(
        input bcd_t s, input bcd_t m, input bcd_t h,
        input bcd_t d, input bcd_t mo);
        stamp_t r;
        r.second = s;
        r.minute = m;
        r.hour   = h;
        r.date   = d;
        r.month  = mo;
        return r;
    endfunction

    function automatic logic stamp_is_empty(input stamp_t s);
        return (s == STAMP_EMPTY);
    endfunction

endpackage

// File: rtl/stamp_arm.sv
// Tracks whether the keep-first record has already taken its event.
module stamp_arm (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic stb,
    output logic held
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            held <= 1'b0;
        end else if (stb) begin
            held <= 1'b1;
        end
    end
endmodule

// File: rtl/stamp_reg.sv
// One record. The clear has priority over a load.
module stamp_reg
    import pwr_stamp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   load,
    input  stamp_t d,
    output stamp_t q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= STAMP_EMPTY;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/pwr_xfer_stamp.sv
module pwr_xfer_stamp
    import pwr_stamp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [FIELD_W-1:0]  tm_sec,
    input  logic [FIELD_W-1:0]  tm_min,
    input  logic [FIELD_W-1:0]  tm_hour,
    input  logic [FIELD_W-1:0]  tm_date,
    input  logic [FIELD_W-1:0]  tm_month,
    input  logic                to_bat_stb,
    input  logic                to_main_stb,
    input  logic                stamp_clr,
    output logic [STAMP_W-1:0]  bat_stamp,
    output logic [STAMP_W-1:0]  main_stamp
);
    stamp_t               now_t;
    stamp_t               slot_q [N_SLOTS];
    logic [N_SLOTS-1:0]   slot_stb;
    logic [N_SLOTS-1:0]   slot_load;
    logic                 bat_held;

    assign now_t = pack_time(tm_sec, tm_min, tm_hour, tm_date, tm_month);

    assign slot_stb[SLOT_BAT]  = to_bat_stb;
    assign slot_stb[SLOT_MAIN] = to_main_stb;

    stamp_arm u_arm (
        .clk  (clk),
        .rst  (rst),
        .clr  (stamp_clr),
        .stb  (to_bat_stb),
        .held (bat_held)
    );

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        localparam keep_policy_e POL = (i == SLOT_BAT) ? KEEP_FIRST : KEEP_LAST;
        if (POL == KEEP_FIRST) begin : g_first
            assign slot_load[i] = slot_stb[i] & ~bat_held;
        end else begin : g_last
            assign slot_load[i] = slot_stb[i];
        end

        stamp_reg u_reg (
            .clk  (clk),
            .rst  (rst),
            .clr  (stamp_clr),
            .load (slot_load[i]),
            .d    (now_t),
            .q    (slot_q[i])
        );
    end

    assign bat_stamp  = slot_q[SLOT_BAT];
    assign main_stamp = slot_q[SLOT_MAIN];

endmodule

// File: rtl/pwr_stamp_chk.sv
module pwr_stamp_chk
    import pwr_stamp_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               stb_bat,
    input logic               stb_main,
    input logic               clr,
    input logic [STAMP_W-1:0] now_t,
    input logic [STAMP_W-1:0] bat,
    input logic [STAMP_W-1:0] main,
    input logic               held
);
    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bat == '0 && main == '0)); // R1

    AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        ($past(stb_bat) && !$past(clr) && !$past(held)) |-> bat == $past(now_t)); // R2

    AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (rst)
        ($past(held) && !$past(clr)) |-> $stable(bat)); // R3

    AST_LAST_TRACK: assert property (@(posedge clk) disable iff (rst)
        ($past(stb_main) && !$past(clr)) |-> main == $past(now_t)); // R4

    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> (bat == '0 && main == '0 && !held)); // R5

    AST_MAIN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!$past(stb_main) && !$past(clr)) |-> $stable(main)); // R8

    AST_BAT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!$past(stb_bat) && !$past(clr)) |-> $stable(bat)); // R8

    AST_NONZERO_STAMP: assert property (@(posedge clk) disable iff (rst)
        ($past(stb_bat) && !$past(clr) && !$past(held) && ($past(now_t[31:24]) != '0))
        |-> bat != '0); // R9
endmodule

bind pwr_xfer_stamp pwr_stamp_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .stb_bat  (to_bat_stb),
    .stb_main (to_main_stb),
    .clr      (stamp_clr),
    .now_t    (now_t),
    .bat      (bat_stamp),
    .main     (main_stamp),
    .held     (bat_held)
);

// File: tb/test_pwr_xfer_stamp.sv
module test_pwr_xfer_stamp;
    import pwr_stamp_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] tm_sec = '0, tm_min = '0, tm_hour = '0, tm_date = '0, tm_month = '0;
    logic to_bat_stb = 1'b0, to_main_stb = 1'b0, stamp_clr = 1'b0;
    logic [STAMP_W-1:0] bat_stamp, main_stamp;

    always #4 clk = ~clk;

    pwr_xfer_stamp i_pwr_xfer_stamp (
        .clk(clk), .rst(rst),
        .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour),
        .tm_date(tm_date), .tm_month(tm_month),
        .to_bat_stb(to_bat_stb), .to_main_stb(to_main_stb), .stamp_clr(stamp_clr),
        .bat_stamp(bat_stamp), .main_stamp(main_stamp)
    );

    typedef struct {
        logic [STAMP_W-1:0] bat;
        logic [STAMP_W-1:0] main;
        int                 due;
        string              tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    logic done = 1'b0;

    // Reference model state
    logic [STAMP_W-1:0] m_bat = '0, m_main = '0;
    logic               m_held = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare each expectation once its edge has passed
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (bat_stamp !== e.bat || main_stamp !== e.main) begin
                n_fail++;
                $display("FAIL %s: bat=%h main=%h expected bat=%h main=%h",
                         e.tag, bat_stamp, main_stamp, e.bat, e.main);
            end
        end
    end

    function automatic logic [STAMP_W-1:0] lay(
        input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
        input logic [7:0] d, input logic [7:0] mo);
        return {mo, d, h, mi, s};
    endfunction

    // Driver: apply one cycle of stimulus, update model, push expectation
    task automatic step(input logic dn, input logic up, input logic clr,
                        input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                        input logic [7:0] d, input logic [7:0] mo, input string tag);
        exp_t e;
        logic [STAMP_W-1:0] t;
        @(negedge clk);
        tm_sec = s; tm_min = mi; tm_hour = h; tm_date = d; tm_month = mo;
        to_bat_stb = dn; to_main_stb = up; stamp_clr = clr;
        t = lay(s, mi, h, d, mo);
        if (clr) begin
            m_bat = '0; m_main = '0; m_held = 1'b0;
        end else begin
            if (dn && !m_held) begin m_bat = t; m_held = 1'b1; end
            if (up) m_main = t;
        end
        e.bat = m_bat; e.main = m_main; e.due = cyc + 1; e.tag = tag;
        q.push_back(e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_run++;
        if (bat_stamp !== '0 || main_stamp !== '0) begin
            n_fail++;
            $display("FAIL R1: bat=%h main=%h expected 0 0", bat_stamp, main_stamp);
        end
        step(1,0,0, 8'h15, 8'h42, 8'h09, 8'h28, 8'h02, "R2 first capture, R7 layout");
        step(1,0,0, 8'h16, 8'h43, 8'h10, 8'h29, 8'h03, "R3 later entry ignored");
        step(1,0,0, 8'h59, 8'h59, 8'h23, 8'h31, 8'h12, "R3 third entry ignored");
        step(0,1,0, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, "R4 main load, R8 bat untouched");
        step(0,1,0, 8'h30, 8'h31, 8'h12, 8'h15, 8'h11, "R4 main overwrite");
        step(0,0,0, 8'h45, 8'h00, 8'h00, 8'h01, 8'h01, "R8 idle hold");
        step(0,0,1, 8'h46, 8'h00, 8'h00, 8'h01, 8'h01, "R5 clear empties");
        step(1,0,0, 8'h07, 8'h08, 8'h19, 8'h20, 8'h10, "R5 re-armed capture");
        step(0,1,0, 8'h11, 8'h22, 8'h13, 8'h14, 8'h06, "R8 main only");
        step(1,0,1, 8'h12, 8'h22, 8'h13, 8'h14, 8'h06, "R6 clear beats entry");
        step(0,1,1, 8'h13, 8'h22, 8'h13, 8'h14, 8'h06, "R6 clear beats return");
        step(1,1,0, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, "R9 nonzero stamp, R8 both");
        step(0,0,1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, "R5 clear again");
        step(1,1,1, 8'h33, 8'h33, 8'h03, 8'h03, 8'h03, "R6 clear beats both");
        step(0,0,0, 8'h34, 8'h33, 8'h03, 8'h03, 8'h03, "R8 empty stays empty");
        step(1,0,0, 8'h58, 8'h17, 8'h21, 8'h09, 8'h07, "R2 capture after clears");
        step(0,0,0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, "R3 holds");
        @(negedge clk);
        @(negedge clk);
        // Explicit non-empty check on the last battery-entry record
        n_run++;
        if (bat_stamp == '0) begin
            n_fail++;
            $display("FAIL R9: bat=%h expected non-zero", bat_stamp);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule